// File: doc/BRIEF.md
# Hash Engine Status and Interrupt Register Slice

This block is the software-visible register slice that sits between a 32-bit register bus and a hash accelerator core. It holds a two-bit interrupt-enable register, a status register and five read-only 32-bit digest words. The status register has two sticky event flags and one activity flag. The first sticky flag reports that the core's input buffer can take another 16 bits. The second reports that a finished digest has been latched. The activity flag reports that DMA is enabled or still moving data. One level-sensitive interrupt line combines each enabled sticky flag.

Software clears the sticky flags by writing zero to the flag bit. A write to the data-input register also clears the buffer-room flag, and writing the start-calculation bit as 1 also clears the digest-ready flag. When the core raises a flag in the same cycle that software clears it, the flag stays set, so no event is lost. Toward the core, the slice issues a one-cycle strobe with the written word for each data-input write, and a one-cycle start pulse for each start command.

Top module: `hash_stat_regs`

## Requirements
- R1: After reset the status register reads 0x0000_0001, the enable register reads 0, all five digest words read 0 and irq is low.
- R2: The enable register at offset 0x20 stores bit 0 (buffer-room interrupt enable) and bit 1 (digest-ready interrupt enable). Bits 31:2 read as zero whatever was written.
- R3: Status bit 0 at offset 0x24 is set by a core_room_pulse. It is cleared by a write to 0x24 with bit 0 = 0, or by any write to the data-input register at 0x08. A write to 0x24 with bit 0 = 1 leaves it unchanged.
- R4: Status bit 1 is set by core_dig_load. It is cleared by a write to 0x24 with bit 1 = 0, or by a write to the control register at 0x00 with bit 2 = 1. A control write with bit 2 = 0 leaves it unchanged.
- R5: When a hardware set and a software clear of the same sticky flag fall in the same cycle, the flag is 1 after that cycle.
- R6: Status bit 2 reads dma_en OR dma_busy in the same cycle. Writes to it have no effect, and bits 31:3 read zero.
- R7: The digest words are at offsets 0x0C + 4*i for i = 0..4. Word i loads core_digest[32*i+31:32*i] on core_dig_load. Bus writes to these offsets leave them unchanged.
- R8: irq = (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1). It is evaluated from the registered flags and enables.
- R9: Offsets 0x00 and 0x08, and every offset not listed above, read as zero.
- R10: A write to 0x08 makes din_wr_strobe high for exactly the next cycle, with din_word holding the written data. A write to 0x00 with bit 2 = 1 makes calc_start_pulse high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_room_pulse | input | 1 | Core pulse: 16 bits of input buffer free |
| core_dig_load | input | 1 | Core strobe: digest valid, load words and set flag |
| core_digest | input | 160 | Digest value, word i in bits 32*i+31:32*i |
| dma_en | input | 1 | DMA enable level |
| dma_busy | input | 1 | DMA transfer in progress |
| din_wr_strobe | output | 1 | One-cycle strobe after a data-input write |
| din_word | output | 32 | Last word written to the data-input register |
| calc_start_pulse | output | 1 | One-cycle start-calculation pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a core event that lands in the same clock edge as a software clear of the same flag, including the indirect clears through the data-input and control registers. Random stimulus seldom lines these up on purpose. The bench therefore drives the room pulse together with a zero write to the status register, and the digest load together with a start command, as directed cycles. Random cycles then mix pulses, loads, DMA levels and writes to every mapped offset on each cycle, against a reference model that applies set-over-clear.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_DIN  = 'h08;
  localparam int OFF_DIG0 = 'h0C;
  localparam int OFF_IEN  = 'h20;
  localparam int OFF_STS  = 'h24;

  localparam int CTRL_START_BIT = 2;

  typedef struct packed {
    logic dma_act;
    logic dig_rdy;
    logic room;
  } sts_t;
endpackage

// File: rtl/hsr_bus_decode.sv
module hsr_bus_decode
  import hsr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_DIG = 5
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      we,
  input  logic [1:0]                ien,
  input  sts_t                      sts,
  input  logic [NUM_DIG*DATA_W-1:0] dig_flat,
  output logic                      wr_ctrl,
  output logic                      wr_din,
  output logic                      wr_ien,
  output logic                      wr_sts,
  output logic [DATA_W-1:0]         rdata
);
  localparam int BYTES_PER_WORD = DATA_W / 8;

  logic [NUM_DIG-1:0] dig_hit;
  logic               hit_ien;
  logic               hit_sts;

  for (genvar gi = 0; gi < NUM_DIG; gi++) begin : g_dig_hit
    assign dig_hit[gi] = (addr == ADDR_W'(OFF_DIG0 + BYTES_PER_WORD * gi));
  end

  assign hit_ien = (addr == ADDR_W'(OFF_IEN));
  assign hit_sts = (addr == ADDR_W'(OFF_STS));

  always_comb begin
    wr_ctrl = we && (addr == ADDR_W'(OFF_CTRL));
    wr_din  = we && (addr == ADDR_W'(OFF_DIN));
    wr_ien  = we && hit_ien;
    wr_sts  = we && hit_sts;
  end

  always_comb begin
    rdata = '0;
    if (hit_ien) rdata[1:0] = ien;
    if (hit_sts) rdata[2:0] = sts;
    for (int i = 0; i < NUM_DIG; i++) begin
      if (dig_hit[i]) rdata = rdata | dig_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/hsr_status_flags.sv
module hsr_status_flags
  import hsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ien,
  input  logic       wr_sts,
  input  logic       wr_din,
  input  logic       wr_ctrl,
  input  logic [2:0] wd_lo,
  input  logic       room_pulse,
  input  logic       dig_load,
  input  logic       dma_en,
  input  logic       dma_busy,
  output logic [1:0] ien,
  output sts_t       sts,
  output logic       irq
);
  logic [1:0] ien_q, ien_d;
  logic       room_q, room_d, room_clr, room_en;
  logic       rdy_q,  rdy_d,  rdy_clr,  rdy_en;

  always_comb begin
    ien_d    = wd_lo[1:0];
    room_clr = (wr_sts && !wd_lo[0]) || wr_din;
    rdy_clr  = (wr_sts && !wd_lo[1]) || (wr_ctrl && wd_lo[CTRL_START_BIT]);
    room_en  = room_pulse || room_clr;
    rdy_en   = dig_load || rdy_clr;
    // hardware set has priority over any clear in the same cycle
    room_d   = room_pulse;
    rdy_d    = dig_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 2'b00;
      room_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else begin
      if (wr_ien)  ien_q  <= ien_d;
      if (room_en) room_q <= room_d;
      if (rdy_en)  rdy_q  <= rdy_d;
    end
  end

  always_comb begin
    ien         = ien_q;
    sts.room    = room_q;
    sts.dig_rdy = rdy_q;
    sts.dma_act = dma_en | dma_busy;
    irq         = (room_q & ien_q[0]) | (rdy_q & ien_q[1]);
  end
endmodule

// File: rtl/hsr_digest_bank.sv
module hsr_digest_bank #(
  parameter int DATA_W  = 32,
  parameter int NUM_DIG = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NUM_DIG*DATA_W-1:0] din,
  output logic [NUM_DIG*DATA_W-1:0] dout
);
  for (genvar gi = 0; gi < NUM_DIG; gi++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;

    always_comb word_d = din[gi*DATA_W +: DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= word_d;
    end

    assign dout[gi*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/hsr_core_strobes.sv
module hsr_core_strobes
  import hsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_din,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic              din_stb,
  output logic [DATA_W-1:0] din_word,
  output logic              start_pls
);
  logic              stb_q, stb_d;
  logic              start_q, start_d;
  logic [DATA_W-1:0] word_q;

  always_comb begin
    stb_d   = wr_din;
    start_d = wr_ctrl && wdata[CTRL_START_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      start_q <= 1'b0;
      word_q  <= '0;
    end else begin
      stb_q   <= stb_d;
      start_q <= start_d;
      if (wr_din) word_q <= wdata;
    end
  end

  assign din_stb   = stb_q;
  assign din_word  = word_q;
  assign start_pls = start_q;
endmodule

// File: rtl/hash_stat_regs.sv
module hash_stat_regs
  import hsr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_DIG = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      core_room_pulse,
  input  logic                      core_dig_load,
  input  logic [NUM_DIG*DATA_W-1:0] core_digest,
  input  logic                      dma_en,
  input  logic                      dma_busy,
  output logic                      din_wr_strobe,
  output logic [DATA_W-1:0]         din_word,
  output logic                      calc_start_pulse,
  output logic                      irq
);
  logic                      wr_ctrl, wr_din, wr_ien, wr_sts;
  logic [1:0]                ien_q;
  sts_t                      sts_v;
  logic [NUM_DIG*DATA_W-1:0] dig_flat;
  logic                      sts_flag0, sts_flag1;

  assign sts_flag0 = sts_v.room;
  assign sts_flag1 = sts_v.dig_rdy;

  hsr_bus_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_DIG(NUM_DIG)
  ) u_dec (
    .addr    (bus_addr),
    .we      (bus_we),
    .ien     (ien_q),
    .sts     (sts_v),
    .dig_flat(dig_flat),
    .wr_ctrl (wr_ctrl),
    .wr_din  (wr_din),
    .wr_ien  (wr_ien),
    .wr_sts  (wr_sts),
    .rdata   (bus_rdata)
  );

  hsr_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ien    (wr_ien),
    .wr_sts    (wr_sts),
    .wr_din    (wr_din),
    .wr_ctrl   (wr_ctrl),
    .wd_lo     (bus_wdata[2:0]),
    .room_pulse(core_room_pulse),
    .dig_load  (core_dig_load),
    .dma_en    (dma_en),
    .dma_busy  (dma_busy),
    .ien       (ien_q),
    .sts       (sts_v),
    .irq       (irq)
  );

  hsr_digest_bank #(
    .DATA_W (DATA_W),
    .NUM_DIG(NUM_DIG)
  ) u_dig (
    .clk  (clk),
    .rst_n(rst_n),
    .load (core_dig_load),
    .din  (core_digest),
    .dout (dig_flat)
  );

  hsr_core_strobes #(
    .DATA_W(DATA_W)
  ) u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_din   (wr_din),
    .wr_ctrl  (wr_ctrl),
    .wdata    (bus_wdata),
    .din_stb  (din_wr_strobe),
    .din_word (din_word),
    .start_pls(calc_start_pulse)
  );
endmodule

// File: rtl/hsr_checker.sv
module hsr_checker
  import hsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              core_room_pulse,
  input logic              core_dig_load,
  input logic              din_wr_strobe,
  input logic              irq,
  input logic              flag0,
  input logic              flag1,
  input logic [1:0]        ien,
  input logic [DATA_W-1:0] dig0
);
  logic touch0, touch1, din_wr;

  assign din_wr = bus_we && (bus_addr == ADDR_W'(OFF_DIN));
  assign touch0 = bus_we && ((bus_addr == ADDR_W'(OFF_DIN)) || (bus_addr == ADDR_W'(OFF_STS)));
  assign touch1 = bus_we && ((bus_addr == ADDR_W'(OFF_CTRL)) || (bus_addr == ADDR_W'(OFF_STS)));

  AST_ROOM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    core_room_pulse |=> flag0); // R5
  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    core_dig_load |=> flag1); // R4
  AST_FLAG0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !touch0) |=> flag0); // R3
  AST_FLAG1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && !touch1) |=> flag1); // R4
  AST_DIG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_dig_load |=> $stable(dig0)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq); // R8
  AST_DIN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    din_wr |=> din_wr_strobe); // R10
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !din_wr |=> !din_wr_strobe); // R10
endmodule

bind hash_stat_regs hsr_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .core_room_pulse(core_room_pulse),
  .core_dig_load  (core_dig_load),
  .din_wr_strobe  (din_wr_strobe),
  .irq            (irq),
  .flag0          (sts_flag0),
  .flag1          (sts_flag1),
  .ien            (ien_q),
  .dig0           (dig_flat[DATA_W-1:0])
);

// File: tb/sim_hash_stat_regs.sv
`timescale 1ns/1ps
module sim_hash_stat_regs;
  localparam logic [7:0] A_CTRL = 8'h00, A_DIN = 8'h08, A_DIG0 = 8'h0C,
                         A_IEN = 8'h20, A_STS = 8'h24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   bus_addr;
  logic         bus_we;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         core_room_pulse, core_dig_load;
  logic [159:0] core_digest;
  logic         dma_en, dma_busy;
  logic         din_wr_strobe, calc_start_pulse, irq;
  logic [31:0]  din_word;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0]   m_ien;
  logic         m_f0, m_f1;
  logic [159:0] m_dig;
  logic         m_din, m_start;

  always #4 clk = ~clk;

  hash_stat_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_room_pulse(core_room_pulse), .core_dig_load(core_dig_load),
    .core_digest(core_digest), .dma_en(dma_en), .dma_busy(dma_busy),
    .din_wr_strobe(din_wr_strobe), .din_word(din_word),
    .calc_start_pulse(calc_start_pulse), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sts(input logic en, input logic busy);
    return {29'd0, en | busy, m_f1, m_f0};
  endfunction

  function automatic logic exp_irq();
    return (m_f0 & m_ien[0]) | (m_f1 & m_ien[1]);
  endfunction

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_we = 1'b0;
    bus_addr = a;
    #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic dig_chk();
    for (int i = 0; i < 5; i++)
      rd_chk(A_DIG0 + 8'(4 * i), m_dig[i*32 +: 32], "R7 digest word");
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] wd,
                      input logic room, input logic load, input logic [159:0] dg,
                      input logic en, input logic busy);
    logic c0, c1;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    core_room_pulse = room; core_dig_load = load; core_digest = dg;
    dma_en = en; dma_busy = busy;
    @(posedge clk);
    c0 = we && ((a == A_STS && !wd[0]) || a == A_DIN);
    c1 = we && ((a == A_STS && !wd[1]) || (a == A_CTRL && wd[2]));
    m_f0 = room | (m_f0 & ~c0);
    m_f1 = load | (m_f1 & ~c1);
    if (we && a == A_IEN) m_ien = wd[1:0];
    if (load) m_dig = dg;
    m_din = we && a == A_DIN;
    m_start = we && a == A_CTRL && wd[2];
    @(negedge clk);
    core_room_pulse = 1'b0; core_dig_load = 1'b0;
    rd_chk(A_STS, exp_sts(en, busy), "R3/R4/R5/R6 status");
    chk({31'd0, irq}, {31'd0, exp_irq()}, "R8 irq");
    chk({31'd0, din_wr_strobe}, {31'd0, m_din}, "R10 din strobe");
    chk({31'd0, calc_start_pulse}, {31'd0, m_start}, "R10 start pulse");
    if (m_din) chk(din_word, wd, "R10 din word");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [159:0] dg;
    logic [7:0]   a;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = A_STS; bus_wdata = '0;
    core_room_pulse = 1'b0; core_dig_load = 1'b0; core_digest = '0;
    dma_en = 1'b0; dma_busy = 1'b0;
    m_ien = 2'b00; m_f0 = 1'b1; m_f1 = 1'b0; m_dig = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(A_STS, 32'h1, "R1 status reset");
    rd_chk(A_IEN, 32'h0, "R1 enable reset");
    chk({31'd0, irq}, 32'd0, "R1 irq reset");
    dig_chk();
    // R2 reserved bits
    step(1, A_IEN, 32'hFFFF_FFFF, 0, 0, '0, 0, 0);
    rd_chk(A_IEN, 32'h3, "R2 enable readback");
    // R3 write one no effect, write zero clears, din write clears
    step(1, A_STS, 32'hFFFF_FFFF, 0, 0, '0, 0, 0);
    step(1, A_STS, 32'h0000_0002, 0, 0, '0, 0, 0);
    step(0, A_STS, 32'h0, 1, 0, '0, 0, 0);
    step(1, A_DIN, 32'hCAFE_0001, 0, 0, '0, 0, 0);
    // R4 digest load, ctrl write without start, ctrl start
    dg = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0BAD_F00D};
    step(0, A_STS, 32'h0, 0, 1, dg, 0, 0);
    dig_chk();
    step(1, A_CTRL, 32'hFFFF_FFFB, 0, 0, '0, 0, 0);
    step(1, A_CTRL, 32'h0000_0004, 0, 0, '0, 0, 0);
    // R5 set wins over clears
    step(1, A_STS, 32'h0, 1, 0, '0, 0, 0);
    step(1, A_DIN, 32'h1234_5678, 1, 0, '0, 0, 0);
    step(1, A_CTRL, 32'h4, 0, 1, ~dg, 0, 0);
    step(1, A_STS, 32'h0, 0, 1, dg, 0, 0);
    // R7 digest writes ignored; R6 dma bit
    step(1, A_DIG0, 32'hDEAD_BEEF, 0, 0, '0, 0, 0);
    step(1, A_DIG0 + 8'd16, 32'hDEAD_BEEF, 0, 0, '0, 0, 0);
    dig_chk();
    step(1, A_STS, 32'hFFFF_FFFF, 0, 0, '0, 0, 0);
    step(0, A_STS, 32'h0, 0, 0, '0, 1, 0);
    step(0, A_STS, 32'h0, 0, 0, '0, 0, 1);
    step(1, A_STS, 32'hFFFF_FFFF, 0, 0, '0, 1, 1);
    // R9 unmapped and write-only offsets
    rd_chk(A_CTRL, 32'h0, "R9 ctrl reads zero");
    rd_chk(A_DIN, 32'h0, "R9 din reads zero");
    rd_chk(8'h04, 32'h0, "R9 unmapped 04");
    rd_chk(8'h28, 32'h0, "R9 unmapped 28");
    rd_chk(8'hFC, 32'h0, "R9 unmapped FC");
    rd_chk(8'h0D, 32'h0, "R9 misaligned 0D");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      case ($urandom % 10)
        0: a = A_CTRL;
        1: a = A_DIN;
        2, 3: a = A_IEN;
        4, 5, 6: a = A_STS;
        7: a = A_DIG0 + 8'(4 * ($urandom % 5));
        8: a = 8'h30;
        default: a = 8'h04;
      endcase
      dg = {$urandom, $urandom, $urandom, $urandom, $urandom};
      step(($urandom % 3) != 0, a, $urandom, ($urandom % 4) == 0,
           ($urandom % 6) == 0, dg, ($urandom % 3) == 0, ($urandom % 3) == 0);
      if ((k % 200) == 0) begin
        dig_chk();
        rd_chk(A_IEN, {30'd0, m_ien}, "R2 enable random");
      end
    end
    dig_chk();
    finish_run();
  end
endmodule